// File: doc/BRIEF.md
# Special Register Access Controller

This block sits between an instruction that moves data to or from a special register and the registers themselves. The instruction names an 8-bit register number directly. The controller checks whether the current privilege mode may reach that number. It steers a permitted write to the one register that number selects. It returns read data with every reserved bit cleared, and it raises a protection trap when the access is not permitted.

The number space is split into three privilege regions. Low numbers belong to the supervisor. A middle window is open to every mode. The top region is held for virtual registers that software emulates, so any access there traps, even from the supervisor. A small parameterized set of demonstration registers stands behind the controller. Each of them has a mask of writable bits, and all other bits are reserved. Any number not in that set is unimplemented: reads of it return zero and writes to it are dropped.

The request side uses a valid/ready handshake. The controller never applies back-pressure: `req_ready` is always high. Each request is decided in the cycle in which it is presented. The trap flag, the read data and the write strobe are combinational responses to that request. A permitted write updates the selected register at the next rising clock edge.

Top module: `sra_ctrl`

## Requirements
- R1: With `req_valid` high and `req_num` in 0..127, a request with `req_super` low raises `rsp_trap` in the same cycle. A request with `req_super` high does not trap.
- R2: Numbers 128..159 never trap, in either mode.
- R3: Numbers 160..255 always trap, in both modes.
- R4: A trapped request drives no write strobe and leaves every register unchanged. Its read data is zero.
- R5: A permitted read of an implemented number returns the stored value, with its reserved bits at 0. While `req_valid` is low, `rsp_rdata` is zero.
- R6: The implemented registers occupy strobe bits 0 to 3. They are, in order, number 0x00 with writable mask 0xFFFF0000, 0x02 with mask 0x0000FFFF, 0x80 with mask 0xFFFFFFFF, and 0x82 with mask 0x000000FF. A permitted write stores `req_wdata` AND mask, so writing 1 to a reserved bit has no effect. `wr_data` carries the same masked value in the cycle of the strobe.
- R7: A write to an unimplemented number drives no strobe and changes no register.
- R8: A permitted read of an unimplemented number returns all zeros.
- R9: `req_ready` is always high. Reset clears every implemented register to zero.
- R10: At most one bit of `wr_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Always high; the controller never stalls |
| req_num | input | 8 | Special-register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| rsp_rdata | output | 32 | Read data, with reserved bits cleared |
| rsp_trap | output | 1 | Protection trap for the current request |
| wr_stb | output | 4 | One write strobe per implemented register |
| wr_data | output | 32 | Write data after reserved-bit masking |

## Verification
The bench walks all 256 numbers in both modes, first writing and then reading back each one. This exposes off-by-one errors at the region edges 127/128 and 159/160. A design that got those edges wrong would trap at 128 or let a user reach 127. A design that let the supervisor bypass the virtual region would let 160 through in supervisor mode. Writes carry ones in the reserved positions. A design that did not mask on write or on read would return those ones. A design that did not gate the strobe with the trap or with the implemented check would corrupt a register, and that shows up in the final read-back of all four registers.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int unsigned NUM_W  = 8;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    RGN_SUPER = 2'd0,
    RGN_OPEN  = 2'd1,
    RGN_VIRT  = 2'd2
  } region_e;
endpackage

// File: rtl/sra_classify.sv
module sra_classify
  import sra_pkg::*;
#(
  parameter int unsigned N_W     = 8,
  parameter int unsigned OPEN_LO = 128,
  parameter int unsigned VIRT_LO = 160
) (
  input  logic [N_W-1:0] num,
  input  logic           super_mode,
  output logic           allow
);
  localparam logic [N_W-1:0] OPEN_LO_V = N_W'(OPEN_LO);
  localparam logic [N_W-1:0] VIRT_LO_V = N_W'(VIRT_LO);

  region_e region;

  always_comb begin
    if (num >= VIRT_LO_V)      region = RGN_VIRT;
    else if (num >= OPEN_LO_V) region = RGN_OPEN;
    else                       region = RGN_SUPER;
  end

  always_comb begin
    unique case (region)
      RGN_SUPER: allow = super_mode;
      RGN_OPEN:  allow = 1'b1;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/sra_decode.sv
module sra_decode #(
  parameter int unsigned N_REGS = 4,
  parameter int unsigned N_W    = 8,
  parameter logic [N_REGS*N_W-1:0] REG_NUMS = '0
) (
  input  logic [N_W-1:0]    num,
  output logic [N_REGS-1:0] hit,
  output logic              any_hit
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_cmp
    assign hit[g] = (num == REG_NUMS[g*N_W +: N_W]);
  end
  assign any_hit = |hit;
endmodule

// File: rtl/sra_bank.sv
module sra_bank #(
  parameter int unsigned N_REGS = 4,
  parameter int unsigned D_W    = 32,
  parameter logic [N_REGS*D_W-1:0] REG_MASKS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_REGS-1:0]     stb,
  input  logic [D_W-1:0]        wdata,
  output logic [N_REGS*D_W-1:0] q
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [D_W-1:0] MASK = REG_MASKS[g*D_W +: D_W];
    logic [D_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val <= '0;
      else if (stb[g]) val <= wdata & MASK;
    end
    assign q[g*D_W +: D_W] = val & MASK;
  end
endmodule

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
#(
  parameter int unsigned N_REGS  = 4,
  parameter int unsigned OPEN_LO = 128,
  parameter int unsigned VIRT_LO = 160,
  parameter logic [N_REGS*NUM_W-1:0]  REG_NUMS  = {8'h82, 8'h80, 8'h02, 8'h00},
  parameter logic [N_REGS*DATA_W-1:0] REG_MASKS = {32'h0000_00FF, 32'hFFFF_FFFF,
                                                    32'h0000_FFFF, 32'hFFFF_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NUM_W-1:0]  req_num,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_super,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_trap,
  output logic [N_REGS-1:0] wr_stb,
  output logic [DATA_W-1:0] wr_data
);
  logic                     allow;
  logic [N_REGS-1:0]        hit;
  logic                     any_hit;
  logic [N_REGS*DATA_W-1:0] q;
  logic                     go;

  sra_classify #(.N_W(NUM_W), .OPEN_LO(OPEN_LO), .VIRT_LO(VIRT_LO)) u_cls (
    .num(req_num), .super_mode(req_super), .allow(allow)
  );

  sra_decode #(.N_REGS(N_REGS), .N_W(NUM_W), .REG_NUMS(REG_NUMS)) u_dec (
    .num(req_num), .hit(hit), .any_hit(any_hit)
  );

  assign req_ready = 1'b1;
  assign rsp_trap  = req_valid & ~allow;
  assign go        = req_valid & allow & any_hit;
  assign wr_stb    = (go & req_write) ? hit : '0;

  always_comb begin
    rsp_rdata = '0;
    wr_data   = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (hit[i]) begin
        rsp_rdata = rsp_rdata | q[i*DATA_W +: DATA_W];
        wr_data   = wr_data | (req_wdata & REG_MASKS[i*DATA_W +: DATA_W]);
      end
    end
    if (!(go & ~req_write)) rsp_rdata = '0;
    if (!(go & req_write))  wr_data   = '0;
  end

  sra_bank #(.N_REGS(N_REGS), .D_W(DATA_W), .REG_MASKS(REG_MASKS)) u_bank (
    .clk(clk), .rst_n(rst_n), .stb(wr_stb), .wdata(req_wdata), .q(q)
  );
endmodule

// File: rtl/sra_ctrl_chk.sv
module sra_ctrl_chk #(
  parameter int unsigned N_REGS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [7:0]        req_num,
  input logic              req_super,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_trap,
  input logic [N_REGS-1:0] wr_stb
);
  assert_user_low_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_num < 8'd128 && !req_super) |-> rsp_trap);
  assert_super_low_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_num < 8'd128 && req_super) |-> !rsp_trap);
  assert_open_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_num >= 8'd128 && req_num < 8'd160) |-> !rsp_trap);
  assert_virtual_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_num >= 8'd160) |-> rsp_trap);
  assert_trap_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (wr_stb == '0 && rsp_rdata == '0));
  assert_idle_rdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> rsp_rdata == '0);
  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
endmodule

bind sra_ctrl sra_ctrl_chk #(.N_REGS(N_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_num(req_num), .req_super(req_super), .rsp_rdata(rsp_rdata),
  .rsp_trap(rsp_trap), .wr_stb(wr_stb)
);

// File: tb/test_sra_ctrl.sv
module test_sra_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [7:0]  req_num = '0;
  logic        req_write = 0;
  logic [31:0] req_wdata = '0;
  logic        req_super = 0;
  logic [31:0] rsp_rdata;
  logic        rsp_trap;
  logic [3:0]  wr_stb;
  logic [31:0] wr_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sra_ctrl i_sra_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_num(req_num), .req_write(req_write), .req_wdata(req_wdata),
    .req_super(req_super), .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  function automatic int reg_idx(input logic [7:0] n);
    case (n)
      8'h00: return 0;
      8'h02: return 1;
      8'h80: return 2;
      8'h82: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] reg_mask(input int i);
    case (i)
      0: return 32'hFFFF_0000;
      1: return 32'h0000_FFFF;
      2: return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic exp_trap(input logic [7:0] n, input logic s);
    return (n >= 8'd160) || (n < 8'd128 && !s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] n, input logic s, input logic w, input logic [31:0] d);
    int idx;
    logic t;
    @(negedge clk);
    req_valid = 1; req_num = n; req_super = s; req_write = w; req_wdata = d;
    #1;
    idx = reg_idx(n);
    t = exp_trap(n, s);
    // R1 R2 R3: trap decision per region
    check(n >= 8'd160 ? "R3" : (n >= 8'd128 ? "R2" : "R1"), {31'd0, rsp_trap}, {31'd0, t});
    if (w) begin
      // R4 R7 R10: strobe only for permitted implemented numbers
      check(t ? "R4" : (idx < 0 ? "R7" : "R10"), {28'd0, wr_stb},
            (t || idx < 0) ? 32'd0 : (32'd1 << idx));
      if (!t && idx >= 0) begin
        check("R6", wr_data, d & reg_mask(idx));
        model[idx] = d & reg_mask(idx);
      end
    end else begin
      // R5 R8 R4: read data
      check(t ? "R4" : (idx < 0 ? "R8" : "R5"), rsp_rdata,
            (t || idx < 0) ? 32'd0 : model[idx]);
    end
    @(posedge clk);
    #1;
    req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9", {31'd0, req_ready}, 32'd1);
    check("R5", rsp_rdata, 32'd0);
    // R9: reset state of every register
    access(8'h00, 1, 0, 0);
    access(8'h02, 1, 0, 0);
    access(8'h80, 1, 0, 0);
    access(8'h82, 1, 0, 0);
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 256; n++) begin
        logic [31:0] d;
        d = {n[7:0], ~n[7:0], n[7:0] ^ 8'h5A, 8'hC3} ^ (s != 0 ? 32'hFFFF_FFFF : 32'd0);
        access(n[7:0], s[0], 1, d);
        access(n[7:0], s[0], 0, 0);
      end
    end
    // R4 R7: final read-back confirms no stray writes
    access(8'h00, 1, 0, 0);
    access(8'h02, 1, 0, 0);
    access(8'h80, 0, 0, 0);
    access(8'h82, 0, 0, 0);
    @(negedge clk);
    check("R5", rsp_rdata, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule